// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page mappings. An incoming virtual address is split into a page number and a page offset. The page number is compared against the stored page number of every entry in the same cycle. When a valid entry matches, the block reports a hit and forms the physical address from that entry's frame number with the offset passed through unchanged. When nothing matches, the block raises a miss so that a table walker or a fault handler outside the block can find the mapping.

The mapping found outside is written back through a fill port. The fill logic picks the slot. It reuses a slot that already holds the same page number. Failing that, it takes the lowest free slot. When every slot is in use, it evicts the slot named by a round-robin pointer. A flush input drops every mapping in one cycle, for use when the address space changes. The default build has eight entries, a 32-bit virtual address, 4 KB pages and a 16-bit frame number, which gives a 28-bit physical address.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is invalid and the round-robin pointer is 0, so every lookup misses until a fill is made.
- R2: When `lk_req` is high and a valid entry's page number equals `lk_vaddr[31:12]`, `lk_hit` is 1 in that same cycle, with no register on the path.
- R3: On a hit, `lk_paddr` equals the matching entry's frame number in bits [27:12] and `lk_vaddr[11:0]` in bits [11:0]. When there is no hit, `lk_paddr` is 0.
- R4: `lk_miss` is high exactly when `lk_req` is high and no valid entry matches. When `lk_req` is low, both `lk_hit` and `lk_miss` are low.
- R5: A fill chooses its slot in this order: first the valid entry that already holds `fill_vpn`, then the lowest-indexed invalid entry, then the entry named by the round-robin pointer.
- R6: The round-robin pointer advances by one, wrapping from 7 to 0, only on a fill that evicts through the pointer. It stays where it is on fills that overwrite a matching entry or use a free entry.
- R7: No page number is ever held by two valid entries, so at most one entry matches any lookup.
- R8: A cycle with `flush` high clears every valid bit and sets the pointer to 0. From the next cycle, every lookup misses.
- R9: When `flush` and `fill_en` are high in the same cycle, the flush wins and the fill is dropped.
- R10: A fill takes effect at the clock edge. A lookup in the same cycle as the fill sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_req | input | 1 | A lookup is requested this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | A valid entry matched the page number |
| lk_miss | output | 1 | Lookup requested and no entry matched |
| lk_paddr | output | 28 | Translated physical address (0 when no hit) |
| fill_en | input | 1 | Install a mapping at the next edge |
| fill_vpn | input | 20 | Virtual page number of the mapping |
| fill_pfn | input | 16 | Physical frame number of the mapping |
| flush | input | 1 | Invalidate every entry at the next edge |

## Verification
The bench goes after the choice of eviction slot once the array is full. A design that advanced the pointer on free-slot fills, or never advanced it, would evict the wrong mapping, and a later lookup would hit where the reference expects a miss. Refilling a page number that is already resident is exercised to catch a design that installs a second copy: it would return a stale frame or match two entries at once. A flush in the same cycle as a fill, and a lookup in the same cycle as a fill, catch designs that let the fill win or that forward a mapping before it has been written. A long pseudo-random phase then mixes all of these against the behavioural model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int PFN_W = 16;
    localparam int N_ENT = 8;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam int IDX_W = $clog2(N_ENT);

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [N_ENT-1:0] ent_vec_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        pfn_t pfn;
    } tlb_entry_t;

    typedef struct packed {
        logic hit;
        pfn_t pfn;
    } lookup_res_t;

    // Index of the lowest set bit; 0 when none is set.
    function automatic idx_t lowest_set(input ent_vec_t v);
        idx_t r;
        r = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (v[i]) r = idx_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/tlb_cam_array.sv
module tlb_cam_array
    import tlb_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic                        wr_en,
    input  idx_t                        wr_idx,
    input  vpn_t                        wr_vpn,
    input  pfn_t                        wr_pfn,
    input  vpn_t                        lk_vpn,
    input  vpn_t                        fl_vpn,
    output ent_vec_t                    lk_match,
    output ent_vec_t                    fl_match,
    output ent_vec_t                    valid_vec,
    output logic [N_ENT-1:0][PFN_W-1:0] pfn_arr
);
    tlb_entry_t ent [N_ENT];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < N_ENT; i++) ent[i] <= '0;
        end else if (wr_en) begin
            ent[wr_idx] <= '{valid: 1'b1, vpn: wr_vpn, pfn: wr_pfn};
        end
    end

    // One lookup comparator and one fill comparator per entry.
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign lk_match[g]  = ent[g].valid && (ent[g].vpn == lk_vpn);
        assign fl_match[g]  = ent[g].valid && (ent[g].vpn == fl_vpn);
        assign valid_vec[g] = ent[g].valid;
        assign pfn_arr[g]   = ent[g].pfn;
    end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
    import tlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     fill_en,
    input  ent_vec_t fill_match,
    input  ent_vec_t valid_vec,
    output logic     wr_en,
    output idx_t     wr_idx,
    output idx_t     rr_ptr
);
    logic use_rr;

    always_comb begin
        use_rr = 1'b0;
        if (|fill_match) begin
            wr_idx = lowest_set(fill_match);
        end else if (!(&valid_vec)) begin
            wr_idx = lowest_set(~valid_vec);
        end else begin
            wr_idx = rr_ptr;
            use_rr = 1'b1;
        end
    end

    assign wr_en = fill_en && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rr_ptr <= '0;
        end else if (wr_en && use_rr) begin
            rr_ptr <= rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_hit_mux.sv
module tlb_hit_mux
    import tlb_pkg::*;
(
    input  ent_vec_t                    match,
    input  logic [N_ENT-1:0][PFN_W-1:0] pfn_arr,
    output lookup_res_t                 res
);
    // AND-OR select: correct because at most one entry matches.
    always_comb begin
        res.hit = |match;
        res.pfn = '0;
        for (int i = 0; i < N_ENT; i++) begin
            res.pfn = res.pfn | (pfn_arr[i] & {PFN_W{match[i]}});
        end
    end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_req,
    input  logic [VA_W-1:0] lk_vaddr,
    output logic            lk_hit,
    output logic            lk_miss,
    output logic [PA_W-1:0] lk_paddr,
    input  logic            fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic            flush
);
    ent_vec_t                    lk_match;
    ent_vec_t                    fl_match;
    ent_vec_t                    valid_vec;
    logic [N_ENT-1:0][PFN_W-1:0] pfn_arr;
    logic                        wr_en;
    idx_t                        wr_idx;
    idx_t                        rr_ptr;
    lookup_res_t                 res;
    vpn_t                        lk_vpn;
    logic [OFF_W-1:0]            lk_off;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];

    tlb_cam_array u_array (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_vpn    (fill_vpn),
        .wr_pfn    (fill_pfn),
        .lk_vpn    (lk_vpn),
        .fl_vpn    (fill_vpn),
        .lk_match  (lk_match),
        .fl_match  (fl_match),
        .valid_vec (valid_vec),
        .pfn_arr   (pfn_arr)
    );

    tlb_victim_sel u_victim (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .fill_en    (fill_en),
        .fill_match (fl_match),
        .valid_vec  (valid_vec),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .rr_ptr     (rr_ptr)
    );

    tlb_hit_mux u_mux (
        .match   (lk_match),
        .pfn_arr (pfn_arr),
        .res     (res)
    );

    assign lk_hit   = lk_req && res.hit;
    assign lk_miss  = lk_req && !res.hit;
    assign lk_paddr = lk_hit ? {res.pfn, lk_off} : '0;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
    import tlb_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     lk_req,
    input logic     lk_hit,
    input logic     lk_miss,
    input logic     fill_en,
    input logic     flush,
    input ent_vec_t match_vec,
    input ent_vec_t fill_match,
    input ent_vec_t valid_vec,
    input idx_t     rr_ptr
);
    assert_single_match_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_req && (|valid_vec)));

    assert_hit_miss_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss) && ((lk_hit || lk_miss) == lk_req));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0) && (rr_ptr == '0));

    assert_flush_beats_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (flush && fill_en) |=> !lk_hit);

    assert_fill_installs_R5: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush) |=> (valid_vec != '0));

    assert_rr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush && (&valid_vec) && !(|fill_match))
        |=> rr_ptr == $past(rr_ptr) + 1'b1);

    assert_rr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!flush && !(fill_en && (&valid_vec) && !(|fill_match)))
        |=> $stable(rr_ptr));
endmodule

bind xlat_tlb tlb_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_req     (lk_req),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .fill_en    (fill_en),
    .flush      (flush),
    .match_vec  (lk_match),
    .fill_match (fl_match),
    .valid_vec  (valid_vec),
    .rr_ptr     (rr_ptr)
);

// File: tb/tb_xlat_tlb.sv
`timescale 1ns/1ps
module tb_xlat_tlb;
    import tlb_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             lk_req;
    logic [VA_W-1:0]  lk_vaddr;
    logic             lk_hit;
    logic             lk_miss;
    logic [PA_W-1:0]  lk_paddr;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;
    logic             flush;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    bit          m_v   [N_ENT];
    int unsigned m_vpn [N_ENT];
    int unsigned m_pfn [N_ENT];
    int          m_rr;

    always #4 clk = ~clk;

    xlat_tlb dut (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .flush(flush)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N_ENT; i++) begin
            m_v[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0;
        end
        m_rr = 0;
    endtask

    task automatic model_fill(input int unsigned v, input int unsigned p);
        int idx;
        idx = -1;
        for (int i = 0; i < N_ENT; i++)
            if (idx < 0 && m_v[i] && m_vpn[i] == v) idx = i;
        if (idx < 0)
            for (int i = 0; i < N_ENT; i++)
                if (idx < 0 && !m_v[i]) idx = i;
        if (idx < 0) begin
            idx = m_rr;
            m_rr = (m_rr + 1) % N_ENT;
        end
        m_v[idx] = 1; m_vpn[idx] = v; m_pfn[idx] = p;
    endtask

    // One cycle: drive at negedge, check combinational outputs, update model at posedge.
    task automatic step(input logic req, input int unsigned vpn, input int unsigned off,
                        input logic fe, input int unsigned fv, input int unsigned fp,
                        input logic fl, input string tag);
        bit          e_hit;
        int unsigned e_pfn;
        logic [31:0] e_pa;
        @(negedge clk);
        lk_req   = req;
        lk_vaddr = {vpn[VPN_W-1:0], off[OFF_W-1:0]};
        fill_en  = fe;
        fill_vpn = fv[VPN_W-1:0];
        fill_pfn = fp[PFN_W-1:0];
        flush    = fl;
        #1;
        e_hit = 0; e_pfn = 0;
        for (int i = 0; i < N_ENT; i++)
            if (m_v[i] && m_vpn[i] == (vpn & ((1 << VPN_W) - 1))) begin
                e_hit = 1; e_pfn = m_pfn[i];
            end
        e_hit = e_hit && req;
        e_pa  = e_hit ? ((e_pfn << OFF_W) | (off & ((1 << OFF_W) - 1))) : 32'd0;
        check({tag, "/R2"}, "lk_hit", 32'(lk_hit), 32'(e_hit));
        check({tag, "/R4"}, "lk_miss", 32'(lk_miss), 32'(req && !e_hit));
        check({tag, "/R3"}, "lk_paddr", 32'(lk_paddr), e_pa);
        @(posedge clk);
        if (fl) begin
            model_reset();
        end else if (fe) begin
            model_fill(fv & ((1 << VPN_W) - 1), fp & ((1 << PFN_W) - 1));
        end
    endtask

    task automatic look(input int unsigned vpn, input int unsigned off, input string tag);
        step(1'b1, vpn, off, 1'b0, 0, 0, 1'b0, tag);
    endtask

    task automatic fill(input int unsigned v, input int unsigned p, input string tag);
        step(1'b0, 0, 0, 1'b1, v, p, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned lfsr;
        rst = 1'b1; lk_req = 0; lk_vaddr = '0; fill_en = 0;
        fill_vpn = '0; fill_pfn = '0; flush = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        look(20'h00000, 12'h000, "R1");
        look(20'h00100, 12'h123, "R1");

        // R5: free slots fill in index order; R10: same-cycle lookup sees old state
        for (int i = 0; i < N_ENT; i++) begin
            step(1'b1, 32'h100 + i, 12'h0AB, 1'b1, 32'h100 + i, 32'h2A0 + i, 1'b0, "R10");
        end
        for (int i = 0; i < N_ENT; i++) look(32'h100 + i, 32'hFFF - i, "R3");
        step(1'b0, 32'h100, 0, 1'b0, 0, 0, 1'b0, "R4");

        // R6: full array evicts through pointer 0, then 1
        fill(32'h200, 32'h5000, "R6");
        look(32'h100, 12'h010, "R6");
        look(32'h200, 12'h010, "R6");
        fill(32'h201, 32'h5001, "R6");
        look(32'h101, 12'h020, "R6");
        look(32'h201, 12'h020, "R6");

        // R7: refill of a resident page overwrites in place, pointer unchanged
        fill(32'h105, 32'h7777, "R7");
        look(32'h105, 12'h555, "R7");
        fill(32'h202, 32'h5002, "R6");
        look(32'h102, 12'h001, "R6");
        look(32'h105, 12'h001, "R7");

        // R9: flush beats a same-cycle fill
        step(1'b1, 32'h103, 12'h0, 1'b1, 32'h300, 32'h9999, 1'b1, "R9");
        look(32'h300, 12'h0, "R9");
        // R8: every entry gone after flush
        look(32'h103, 12'h0, "R8");
        fill(32'h300, 32'h1234, "R8");
        fill(32'h301, 32'h4321, "R8");
        step(1'b0, 0, 0, 1'b0, 0, 0, 1'b1, "R8");
        look(32'h300, 12'h777, "R8");
        look(32'h301, 12'h777, "R8");

        // Mixed pseudo-random traffic over a small page space
        lfsr = 32'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0] | lfsr[1], lfsr[7:4], lfsr[19:8],
                 lfsr[2] & ~lfsr[3], lfsr[11:8], lfsr[27:12],
                 (lfsr[31:26] == 6'h3F), "R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule